// File: doc/BRIEF.md
# Nibble-Mode DRAM Strobe to Flat SRAM Address Translator

This block lets a legacy host that was built for nibble-mode DRAM drive a flat-addressed pseudo-static RAM. The host presents a 9-bit multiplexed address together with active-low row and column strobes. The block samples all of them with a free-running system clock, through two-flop synchronisers followed by falling-edge detectors. It captures the row half on the row-strobe fall and the column half on the first column-strobe fall. It then issues four read-access requests, each one a single-cycle strobe carrying the full memory address.

During the first request the address comes straight from the captured halves. The three requests that follow ignore the address bus and step the held address. The step either carries across all 18 bits or wraps within the lowest two bits, chosen by a parameter. Column strobes that arrive with no row cycle open are ignored. So are column strobes inside a refresh cycle, which opens with the column strobe already low when the row strobe falls. The 18-bit address is zero-extended onto a 23-bit memory bus and added to a base-offset parameter.

The controller has five states. `ST_IDLE` waits for a row-strobe fall. From `ST_IDLE`, a row-strobe fall with the column strobe high goes to `ST_ROW` and captures the row, while a row-strobe fall with the column strobe low goes to `ST_REFRESH`. From `ST_ROW`, a column-strobe fall goes to `ST_BURST`, capturing the column and issuing the first request. `ST_BURST` issues one stepped request per column-strobe fall and moves to `ST_DONE` on the fourth. In `ST_DONE` and `ST_REFRESH`, column-strobe falls are ignored. From `ST_ROW`, `ST_BURST`, `ST_DONE` and `ST_REFRESH`, a high row strobe returns the controller to `ST_IDLE`, which also aborts a burst that is not finished.

Top module: `nibble_dram_xlate`

## Requirements
- R1: A synchronous active-high reset forces the idle state, holds `access_vld` low and clears `mem_addr` to zero.
- R2: On a falling edge of `ras_n` while `cas_n` is high, the value on `dram_addr` becomes bits 17:9 of the assembled address.
- R3: On the first falling edge of `cas_n` after R2, the value on `dram_addr` becomes bits 8:0, and the first access is issued with that full address.
- R4: Exactly three further falling edges of `cas_n` in the same row cycle each issue one access; `dram_addr` is ignored on those edges.
- R5: With `STEP_MODE` linear, each later access address is the previous one plus one, modulo 2^18, carrying across the column/row boundary.
- R6: With `STEP_MODE` nibble-wrap, only address bits 1:0 increment (3 wraps to 0), and bits 17:2 stay fixed.
- R7: Falling edges of `cas_n` after the fourth access in a row cycle issue no access.
- R8: A `ras_n` fall while `cas_n` is low starts a refresh cycle; no `cas_n` edge issues an access until `ras_n` returns high. A `cas_n` fall with no row cycle open is also ignored.
- R9: If `ras_n` rises before four accesses have been issued, the burst ends, and later `cas_n` falls issue no access until a new R2 capture.
- R10: `access_vld` is high for exactly one cycle per accepted `cas_n` fall. It rises on the third rising clock edge after the `cas_n` input falls.
- R11: `mem_addr` equals `MEM_BASE` plus the 18-bit address zero-extended to 23 bits, and it is valid while `access_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Asynchronous row strobe, active low |
| cas_n | input | 1 | Asynchronous column strobe, active low |
| dram_addr | input | 9 | Multiplexed row/column address |
| mem_addr | output | 23 | Flat memory address for the current access |
| access_vld | output | 1 | One-cycle read-access request |

## Verification
The hardest situations to reach are the ones where a `cas_n` fall has to be rejected: a refresh cycle whose row strobe falls while the column strobe is already low, a burst aborted halfway, and a fifth column pulse. The stimulus tasks order the two strobes explicitly, several clocks apart, so each ordering reaches the synchronised samples unambiguously. After each pulse the bench watches `access_vld` in the exact cycle an access would appear. The later beats drive a deliberately wrong value on `dram_addr`, so that any use of the bus shows up in the address. A column value of 0x1FF exercises the carry into the row bits. Two instances, one per step mode, see the same strobes.

// File: rtl/nibx_pkg.sv
package nibx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ROW     = 3'd1,
        ST_BURST   = 3'd2,
        ST_DONE    = 3'd3,
        ST_REFRESH = 3'd4
    } nibx_state_e;

    typedef enum logic {
        STEP_LINEAR = 1'b0,
        STEP_WRAP   = 1'b1
    } nibx_step_e;

endpackage

// File: rtl/nibx_sync.sv
module nibx_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/nibx_edge.sv
module nibx_edge (
    input  logic clk,
    input  logic rst,
    input  logic ras_s,
    input  logic cas_s,
    output logic ras_fall,
    output logic cas_fall,
    output logic ras_hi,
    output logic cas_hi
);
    logic ras_prev_q;
    logic cas_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_prev_q <= 1'b1;
            cas_prev_q <= 1'b1;
        end else begin
            ras_prev_q <= ras_s;
            cas_prev_q <= cas_s;
        end
    end

    assign ras_fall = ras_prev_q & ~ras_s;
    assign cas_fall = cas_prev_q & ~cas_s;
    assign ras_hi   = ras_s;
    assign cas_hi   = cas_s;
endmodule

// File: rtl/nibx_step.sv
module nibx_step #(
    parameter int                   W         = 18,
    parameter nibx_pkg::nibx_step_e STEP_MODE = nibx_pkg::STEP_LINEAR
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    generate
        if (STEP_MODE == nibx_pkg::STEP_WRAP) begin : g_wrap
            logic [1:0] low_inc;
            assign low_inc = cur[1:0] + 2'd1;
            assign nxt     = {cur[W-1:2], low_inc};
        end else begin : g_linear
            assign nxt = cur + W'(1);
        end
    endgenerate
endmodule

// File: rtl/nibble_dram_xlate.sv
module nibble_dram_xlate #(
    parameter int                   HALF_W    = 9,
    parameter int                   MEM_AW    = 23,
    parameter int                   BEATS     = 4,
    parameter logic [MEM_AW-1:0]    MEM_BASE  = '0,
    parameter nibx_pkg::nibx_step_e STEP_MODE = nibx_pkg::STEP_LINEAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic [HALF_W-1:0] dram_addr,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              access_vld
);
    import nibx_pkg::*;

    localparam int FULL_W = 2 * HALF_W;
    localparam int BEAT_W = $clog2(BEATS + 1);

    // synchronised strobes and address, equal latency
    logic              ras_s, cas_s;
    logic [HALF_W-1:0] addr_s;

    nibx_sync #(.W(2), .RST_VAL(2'b11)) u_sync_strobe (
        .clk (clk),
        .rst (rst),
        .d   ({ras_n, cas_n}),
        .q   ({ras_s, cas_s})
    );

    nibx_sync #(.W(HALF_W), .RST_VAL('0)) u_sync_addr (
        .clk (clk),
        .rst (rst),
        .d   (dram_addr),
        .q   (addr_s)
    );

    logic ras_fall, cas_fall, ras_hi, cas_hi;

    nibx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .ras_s    (ras_s),
        .cas_s    (cas_s),
        .ras_fall (ras_fall),
        .cas_fall (cas_fall),
        .ras_hi   (ras_hi),
        .cas_hi   (cas_hi)
    );

    nibx_state_e       state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [HALF_W-1:0] row_q, row_d;
    logic [FULL_W-1:0] addr_q, addr_d;
    logic [FULL_W-1:0] step_nxt;
    logic              emit;

    nibx_step #(.W(FULL_W), .STEP_MODE(STEP_MODE)) u_step (
        .cur (addr_q),
        .nxt (step_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        row_d   = row_q;
        addr_d  = addr_q;
        emit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (cas_hi) begin
                        row_d   = addr_s;
                        state_d = ST_ROW;
                    end else begin
                        state_d = ST_REFRESH;
                    end
                end
            end
            ST_ROW: begin
                if (ras_hi) begin
                    state_d = ST_IDLE;
                end else if (cas_fall) begin
                    addr_d  = {row_q, addr_s};
                    beat_d  = BEAT_W'(1);
                    emit    = 1'b1;
                    state_d = (BEATS == 1) ? ST_DONE : ST_BURST;
                end
            end
            ST_BURST: begin
                if (ras_hi) begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end else if (cas_fall) begin
                    addr_d = step_nxt;
                    beat_d = beat_q + BEAT_W'(1);
                    emit   = 1'b1;
                    if (beat_q == BEAT_W'(BEATS - 1)) begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE, ST_REFRESH: begin
                if (ras_hi) begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            row_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            row_q   <= row_d;
            addr_q  <= addr_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            access_vld <= 1'b0;
            mem_addr   <= '0;
        end else begin
            access_vld <= emit;
            if (emit) begin
                mem_addr <= MEM_BASE + MEM_AW'(addr_d);
            end
        end
    end

    // ---------------- assertions ----------------
    logic [FULL_W-1:0] chk_prev_q;
    always_ff @(posedge clk) begin
        if (rst)             chk_prev_q <= '0;
        else if (access_vld) chk_prev_q <= addr_q;
    end

    assert_vld_single_R10: assert property (@(posedge clk) disable iff (rst)
        access_vld |=> !access_vld);

    assert_refresh_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && ras_fall && !cas_hi) |=> state_q == ST_REFRESH);

    assert_refresh_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REFRESH) |=> !access_vld);

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !access_vld);

    assert_beat_bound_R7: assert property (@(posedge clk) disable iff (rst)
        beat_q <= BEAT_W'(BEATS));

    assert_done_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> !access_vld);

    assert_ras_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (ras_hi && state_q != ST_IDLE) |=> state_q == ST_IDLE);

    assert_out_map_R11: assert property (@(posedge clk) disable iff (rst)
        access_vld |-> mem_addr == MEM_BASE + MEM_AW'(addr_q));

    generate
        if (STEP_MODE == STEP_WRAP) begin : g_chk_wrap
            assert_wrap_step_R6: assert property (@(posedge clk) disable iff (rst)
                (access_vld && beat_q != BEAT_W'(1)) |->
                (addr_q[FULL_W-1:2] == chk_prev_q[FULL_W-1:2] &&
                 addr_q[1:0] == chk_prev_q[1:0] + 2'd1));
        end else begin : g_chk_linear
            assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
                (access_vld && beat_q != BEAT_W'(1)) |->
                addr_q == chk_prev_q + FULL_W'(1));
        end
    endgenerate

endmodule

// File: tb/nibble_dram_xlate_tb.sv
module nibble_dram_xlate_tb;
    localparam logic [22:0] BASE_LIN = 23'h40_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic [8:0]  dram_addr = '0;
    logic [22:0] lin_addr, wrp_addr;
    logic        lin_vld, wrp_vld;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    nibble_dram_xlate #(.MEM_BASE(BASE_LIN), .STEP_MODE(nibx_pkg::STEP_LINEAR)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .dram_addr(dram_addr),
        .mem_addr(lin_addr), .access_vld(lin_vld)
    );

    nibble_dram_xlate #(.MEM_BASE(23'h0), .STEP_MODE(nibx_pkg::STEP_WRAP)) u_dut_wrap (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .dram_addr(dram_addr),
        .mem_addr(wrp_addr), .access_vld(wrp_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [22:0] exp_lin(input logic [17:0] full, input int k);
        logic [17:0] a;
        a = full + 18'(k);
        return BASE_LIN + {5'b0, a};
    endfunction

    function automatic logic [22:0] exp_wrp(input logic [17:0] full, input int k);
        logic [1:0] lo;
        lo = full[1:0] + 2'(k);
        return {5'b0, full[17:2], lo};
    endfunction

    task automatic ras_down(input logic [8:0] row);
        @(negedge clk);
        dram_addr = row;
        ras_n     = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ras_up();
        @(negedge clk);
        ras_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // one column pulse; checks the access window and the cycle after
    task automatic cas_beat(input logic [8:0] a, input bit exp_vld, input logic [17:0] full,
                            input int k, input string req);
        @(negedge clk);
        dram_addr = a;
        cas_n     = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({req, " vld lin"}, 32'(lin_vld), 32'(exp_vld));
        chk({req, " vld wrap"}, 32'(wrp_vld), 32'(exp_vld));
        if (exp_vld) begin
            chk({req, " R11 addr lin"}, 32'(lin_addr), 32'(exp_lin(full, k)));
            chk({req, " R11 addr wrap"}, 32'(wrp_addr), 32'(exp_wrp(full, k)));
        end
        @(negedge clk);
        chk("R10 pulse ends lin", 32'(lin_vld), 32'h0);
        chk("R10 pulse ends wrap", 32'(wrp_vld), 32'h0);
        cas_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 vld lin", 32'(lin_vld), 32'h0);
        chk("R1 vld wrap", 32'(wrp_vld), 32'h0);
        chk("R1 addr lin", 32'(lin_addr), 32'h0);
        chk("R1 addr wrap", 32'(wrp_addr), 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_burst(input logic [8:0] row, input logic [8:0] col, input string req);
        logic [17:0] full;
        full = {row, col};
        ras_down(row);
        cas_beat(col, 1'b1, full, 0, {req, " R2 R3 first"});
        for (int k = 1; k < 4; k++) begin
            cas_beat(col ^ 9'h1AA, 1'b1, full, k, {req, " R4 later beat"});
        end
        cas_beat(9'h155, 1'b0, full, 0, "R7 fifth pulse");
        cas_beat(9'h0F0, 1'b0, full, 0, "R7 sixth pulse");
        ras_up();
    endtask

    task automatic t_refresh();
        cas_beat(9'h0AA, 1'b0, '0, 0, "R8 idle cas");
        @(negedge clk);
        cas_n = 1'b0;
        repeat (6) @(negedge clk);
        dram_addr = 9'h111;
        ras_n     = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 refresh lin", 32'(lin_vld), 32'h0);
        cas_n = 1'b1;
        repeat (6) @(negedge clk);
        cas_beat(9'h022, 1'b0, '0, 0, "R8 cas in refresh a");
        cas_beat(9'h033, 1'b0, '0, 0, "R8 cas in refresh b");
        ras_up();
        t_burst(9'h111, 9'h022, "R8 recovery");
    endtask

    task automatic t_abort();
        logic [17:0] full;
        full = {9'h1C3, 9'h004};
        ras_down(9'h1C3);
        cas_beat(9'h004, 1'b1, full, 0, "R9 pre-abort first");
        cas_beat(9'h0FF, 1'b1, full, 1, "R9 pre-abort second");
        ras_up();
        cas_beat(9'h004, 1'b0, full, 0, "R9 after abort a");
        cas_beat(9'h004, 1'b0, full, 0, "R9 after abort b");
        ras_down(9'h0EE);
        ras_up();
        cas_beat(9'h012, 1'b0, full, 0, "R9 abort before cas");
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_burst(9'h0A5, 9'h133, "R5 R6 plain");
        t_burst(9'h07F, 9'h1FF, "R5 carry");
        t_burst(9'h12C, 9'h1FE, "R6 wrap");
        t_refresh();
        t_abort();
        t_burst(9'h1FF, 9'h1FF, "R5 top wrap");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule